// File: doc/BRIEF.md
# Audio Control Command Decoder

This block takes a stream of 8-bit control bytes, each marked by a one-cycle valid strobe. It uses the leading bits of each byte to pick which control register the byte writes. The registers are master volume, left speaker attenuation, right speaker attenuation, input selection with two general-purpose output bits, bass, and treble. Downstream analog switching logic reads the register contents directly.

Besides the raw register codes, the block produces three kinds of derived value:
- a total attenuation for each speaker, in 1.25 dB units, which combines the master volume with that speaker's attenuation;
- a mute flag for each speaker;
- a signed tone gain for bass and for treble, in 2 dB units.

Bytes whose prefix is not a valid command are dropped and counted. Reset loads the power-on state.

Top module: `audio_cmd_regs`

## Requirements
- R1: While `rst_ni` is low, the outputs take these values: volume code 63, both speaker codes 31 (muted), input index 0, `dig_out_o` = 2'b11, bass and treble codes 4'b1110 (gain +1, that is +2 dB), and error count 0.
- R2: A valid byte `00xxxxxx` loads its low six bits into the volume code. The volume attenuation in 1.25 dB steps equals the code, which is coarse bits [5:3] × 8 plus fine bits [2:0]. For example, 0x24 gives 36 steps (45 dB).
- R3: A valid byte `100xxxxx` loads its low five bits into the left speaker code. A valid byte `101xxxxx` loads them into the right speaker code. The speaker attenuation in steps equals the code (coarse bits [4:3] × 8 + fine bits [2:0]). For example, 0xB4 sets the right code to 20 (25 dB).
- R4: A speaker code of 31 means mute. The mute flag is 1 exactly when the code is 31.
- R5: A valid byte `010d2d1s2s1s0` sets `input_sel_o` = {s1,s0} and `dig_out_o` = {d2,d1}. Bit s2 has no effect.
- R6: A valid byte `0110cccc` loads the bass code and a valid byte `0111cccc` loads the treble code.
- R7: The tone gain for code c is −(7 − c[2:0]) when c[3] = 0 and +(7 − c[2:0]) when c[3] = 1. For example, 0x62 gives bass −5 (−10 dB).
- R8: A speaker's total attenuation is the volume code plus that speaker's code, or 127 while that speaker is muted.
- R9: A valid byte `11xxxxxx` changes no register and increments the error count by one.
- R10: The error count saturates at its maximum value (255 by default).
- R11: Registers update on the first clock edge at which the strobe is high. A byte with the strobe low has no effect.
- R12: Each byte changes only the register its prefix selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 8 | Command byte |
| cmd_valid_i | input | 1 | One-cycle byte strobe |
| vol_code_o | output | 6 | Volume code (1.25 dB steps) |
| spk_l_code_o | output | 5 | Left speaker code |
| spk_r_code_o | output | 5 | Right speaker code |
| spk_l_mute_o | output | 1 | Left speaker muted |
| spk_r_mute_o | output | 1 | Right speaker muted |
| tot_l_steps_o | output | 7 | Left total attenuation, 127 when muted |
| tot_r_steps_o | output | 7 | Right total attenuation, 127 when muted |
| input_sel_o | output | 2 | Selected stereo input index |
| dig_out_o | output | 2 | General-purpose outputs {d2,d1} |
| bass_code_o | output | 4 | Raw bass code |
| treble_code_o | output | 4 | Raw treble code |
| bass_gain_o | output | 4 | Signed bass gain (2 dB units) |
| treble_gain_o | output | 4 | Signed treble gain (2 dB units) |
| err_cnt_o | output | 8 | Saturating count of rejected bytes |

## Verification
The hardest state to reach from the ports is the saturated error counter, and reaching it must not disturb any control register. The bench first sweeps all 256 byte values, comparing every output against an arithmetic model after each byte. It then sends a long run of `11` prefix bytes, enough to carry the counter past its maximum. While it does so, it confirms after every byte that the count stops at 255 and that all other outputs keep their values.

// File: rtl/audio_cmd_pkg.sv
package audio_cmd_pkg;
  localparam int VOL_W  = 6;
  localparam int SPK_W  = 5;
  localparam int TONE_W = 4;
  localparam int SEL_W  = 2;
  localparam int DIG_W  = 2;
  localparam int TOT_W  = 7;
  localparam int N_SPK  = 2;
  localparam int N_TONE = 2;

  typedef struct packed {
    logic vol;
    logic spk_l;
    logic spk_r;
    logic sel;
    logic bass;
    logic treb;
    logic bad;
  } cmd_we_t;

  localparam logic [VOL_W-1:0]  VOL_RST  = '1;
  localparam logic [SPK_W-1:0]  SPK_RST  = '1;
  localparam logic [TONE_W-1:0] TONE_RST = 4'b1110;
  localparam logic [SEL_W-1:0]  SEL_RST  = '0;
  localparam logic [DIG_W-1:0]  DIG_RST  = '1;
endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
  import audio_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [7:0] byte_i,
  output cmd_we_t    we_o
);
  always_comb begin
    we_o = '0;
    if (valid_i) begin
      casez (byte_i)
        8'b00??????: we_o.vol   = 1'b1;
        8'b100?????: we_o.spk_l = 1'b1;
        8'b101?????: we_o.spk_r = 1'b1;
        8'b010?????: we_o.sel   = 1'b1;
        8'b0110????: we_o.bass  = 1'b1;
        8'b0111????: we_o.treb  = 1'b1;
        default:     we_o.bad   = 1'b1;
      endcase
    end
  end

  // R12
  single_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_o));
  // R11
  idle_no_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (we_o == '0));
endmodule

// File: rtl/spk_chan.sv
module spk_chan
  import audio_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SPK_W-1:0] field_i,
  input  logic [VOL_W-1:0] vol_i,
  output logic [SPK_W-1:0] code_o,
  output logic             mute_o,
  output logic [TOT_W-1:0] tot_o
);
  logic [SPK_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   code_q <= SPK_RST;
    else if (we_i) code_q <= field_i;
  end

  assign code_o = code_q;
  assign mute_o = &code_q;
  // coarse*8+fine is the code itself; widths zero-extended
  assign tot_o  = mute_o ? '1 : (TOT_W'(vol_i) + TOT_W'(code_q));

  // R3
  spk_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> code_o == $past(field_i));
  // R12
  spk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(code_o));
endmodule

// File: rtl/tone_map.sv
module tone_map
  import audio_cmd_pkg::*;
(
  input  logic [TONE_W-1:0]        code_i,
  output logic signed [TONE_W-1:0] gain_o
);
  logic [TONE_W-2:0] mag;

  always_comb begin
    mag    = 3'd7 - code_i[TONE_W-2:0];
    gain_o = code_i[TONE_W-1] ? $signed({1'b0, mag}) : -$signed({1'b0, mag});
  end
endmodule

// File: rtl/audio_cmd_regs.sv
module audio_cmd_regs
  import audio_cmd_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        cmd_i,
  input  logic              cmd_valid_i,
  output logic [5:0]        vol_code_o,
  output logic [4:0]        spk_l_code_o,
  output logic [4:0]        spk_r_code_o,
  output logic              spk_l_mute_o,
  output logic              spk_r_mute_o,
  output logic [6:0]        tot_l_steps_o,
  output logic [6:0]        tot_r_steps_o,
  output logic [1:0]        input_sel_o,
  output logic [1:0]        dig_out_o,
  output logic [3:0]        bass_code_o,
  output logic [3:0]        treble_code_o,
  output logic signed [3:0] bass_gain_o,
  output logic signed [3:0] treble_gain_o,
  output logic [ERR_W-1:0]  err_cnt_o
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  cmd_we_t we;
  logic [VOL_W-1:0]  vol_q;
  logic [SEL_W-1:0]  sel_q;
  logic [DIG_W-1:0]  dig_q;
  logic [TONE_W-1:0] tone_q [N_TONE];
  logic [ERR_W-1:0]  err_q;
  logic              spk_we   [N_SPK];
  logic [SPK_W-1:0]  spk_code [N_SPK];
  logic              spk_mute [N_SPK];
  logic [TOT_W-1:0]  spk_tot  [N_SPK];
  logic              tone_we  [N_TONE];
  logic signed [TONE_W-1:0] tone_gain [N_TONE];

  cmd_classify i_cmd_classify (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(cmd_valid_i),
    .byte_i (cmd_i),
    .we_o   (we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_q <= VOL_RST;
      sel_q <= SEL_RST;
      dig_q <= DIG_RST;
      err_q <= '0;
    end else begin
      if (we.vol) vol_q <= cmd_i[VOL_W-1:0];
      if (we.sel) begin
        sel_q <= cmd_i[SEL_W-1:0];
        dig_q <= cmd_i[4:3];
      end
      if (we.bad && (err_q != ERR_MAX)) err_q <= err_q + 1'b1;
    end
  end

  assign spk_we[0] = we.spk_l;
  assign spk_we[1] = we.spk_r;
  assign tone_we[0] = we.bass;
  assign tone_we[1] = we.treb;

  for (genvar s = 0; s < N_SPK; s++) begin : g_spk
    spk_chan i_spk_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (spk_we[s]),
      .field_i(cmd_i[SPK_W-1:0]),
      .vol_i  (vol_q),
      .code_o (spk_code[s]),
      .mute_o (spk_mute[s]),
      .tot_o  (spk_tot[s])
    );
  end

  for (genvar t = 0; t < N_TONE; t++) begin : g_tone
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         tone_q[t] <= TONE_RST;
      else if (tone_we[t]) tone_q[t] <= cmd_i[TONE_W-1:0];
    end
    tone_map i_tone_map (
      .code_i(tone_q[t]),
      .gain_o(tone_gain[t])
    );
  end

  assign vol_code_o    = vol_q;
  assign spk_l_code_o  = spk_code[0];
  assign spk_r_code_o  = spk_code[1];
  assign spk_l_mute_o  = spk_mute[0];
  assign spk_r_mute_o  = spk_mute[1];
  assign tot_l_steps_o = spk_tot[0];
  assign tot_r_steps_o = spk_tot[1];
  assign input_sel_o   = sel_q;
  assign dig_out_o     = dig_q;
  assign bass_code_o   = tone_q[0];
  assign treble_code_o = tone_q[1];
  assign bass_gain_o   = tone_gain[0];
  assign treble_gain_o = tone_gain[1];
  assign err_cnt_o     = err_q;

  // R9
  err_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i[7:6] == 2'b11 && err_cnt_o != ERR_MAX)
      |=> err_cnt_o == $past(err_cnt_o) + 1'b1);
  // R9
  err_no_touch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i[7:6] == 2'b11)
      |=> $stable(vol_code_o) && $stable(input_sel_o) && $stable(dig_out_o)
          && $stable(bass_code_o) && $stable(treble_code_o));
  // R10
  err_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o == ERR_MAX) |=> err_cnt_o == ERR_MAX);
  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable(vol_code_o) && $stable(err_cnt_o) && $stable(dig_out_o));
  // R7
  tone_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bass_code_o[2:0] == 3'b111) |-> bass_gain_o == 4'sd0);
  // R8
  mute_tot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spk_l_mute_o |-> tot_l_steps_o == 7'd127);
endmodule

// File: tb/test_audio_cmd_regs.sv
module test_audio_cmd_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cmd = '0;
  logic cmd_valid = 1'b0;
  logic [5:0] vol_code;
  logic [4:0] spk_l_code, spk_r_code;
  logic spk_l_mute, spk_r_mute;
  logic [6:0] tot_l, tot_r;
  logic [1:0] input_sel, dig_out;
  logic [3:0] bass_code, treble_code;
  logic signed [3:0] bass_gain, treble_gain;
  logic [7:0] err_cnt;

  int n_chk = 0;
  int n_fail = 0;
  int m_vol, m_sl, m_sr, m_sel, m_dig, m_bass, m_treb, m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_cmd_regs i_audio_cmd_regs (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .cmd_valid_i(cmd_valid),
    .vol_code_o(vol_code), .spk_l_code_o(spk_l_code), .spk_r_code_o(spk_r_code),
    .spk_l_mute_o(spk_l_mute), .spk_r_mute_o(spk_r_mute),
    .tot_l_steps_o(tot_l), .tot_r_steps_o(tot_r),
    .input_sel_o(input_sel), .dig_out_o(dig_out),
    .bass_code_o(bass_code), .treble_code_o(treble_code),
    .bass_gain_o(bass_gain), .treble_gain_o(treble_gain),
    .err_cnt_o(err_cnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int gain_of(input int c);
    int mag = 7 - (c % 8);
    return (c >= 8) ? mag : -mag;
  endfunction

  function automatic int tot_of(input int v, input int s);
    return (s == 31) ? 127 : v + s;
  endfunction

  task automatic check_all(input string ctx);
    chk({ctx, " R2 vol"}, int'(vol_code), m_vol);
    chk({ctx, " R3 spk_l"}, int'(spk_l_code), m_sl);
    chk({ctx, " R3 spk_r"}, int'(spk_r_code), m_sr);
    chk({ctx, " R4 mute"}, {int'(spk_l_mute), int'(spk_r_mute)} == {int'(m_sl == 31), int'(m_sr == 31)} ? 1 : 0, 1);
    chk({ctx, " R5 sel"}, int'(input_sel), m_sel);
    chk({ctx, " R5 dig"}, int'(dig_out), m_dig);
    chk({ctx, " R6 bass"}, int'(bass_code), m_bass);
    chk({ctx, " R6 treble"}, int'(treble_code), m_treb);
    chk({ctx, " R7 bass_gain"}, int'(bass_gain), gain_of(m_bass));
    chk({ctx, " R7 treble_gain"}, int'(treble_gain), gain_of(m_treb));
    chk({ctx, " R8 tot_l"}, int'(tot_l), tot_of(m_vol, m_sl));
    chk({ctx, " R8 tot_r"}, int'(tot_r), tot_of(m_vol, m_sr));
    chk({ctx, " R9 err"}, int'(err_cnt), m_err);
  endtask

  // apply a byte, update the model, compare after the capturing edge
  task automatic send(input logic [7:0] b, input logic vld);
    @(negedge clk);
    cmd = b;
    cmd_valid = vld;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (vld) begin
      casez (b)
        8'b00??????: m_vol = int'(b[5:0]);
        8'b100?????: m_sl = int'(b[4:0]);
        8'b101?????: m_sr = int'(b[4:0]);
        8'b010?????: begin m_sel = int'(b[1:0]); m_dig = int'(b[4:3]); end
        8'b0110????: m_bass = int'(b[3:0]);
        8'b0111????: m_treb = int'(b[3:0]);
        default: if (m_err < 255) m_err++;
      endcase
    end
  endtask

  initial begin
    m_vol = 63; m_sl = 31; m_sr = 31; m_sel = 0; m_dig = 3;
    m_bass = 14; m_treb = 14; m_err = 0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    chk("R1 bass_gain +1", int'(bass_gain), 1);
    rst_n = 1'b1;

    // R11, R12: full sweep, every output compared after each byte
    for (int i = 0; i < 256; i++) begin
      send(8'(i), 1'b1);
      check_all("sweep R12");
    end

    // R11: strobe low, no effect
    for (int i = 0; i < 256; i += 17) begin
      send(8'(i), 1'b0);
      check_all("R11 idle");
    end

    send(8'h24, 1'b1);
    chk("R2 0x24 vol", int'(vol_code), 36);
    send(8'hB4, 1'b1);
    chk("R3 0xB4 spk_r", int'(spk_r_code), 20);
    chk("R4 0xB4 unmuted", int'(spk_r_mute), 0);
    chk("R8 0xB4 tot_r", int'(tot_r), 56);
    send(8'h62, 1'b1);
    chk("R7 0x62 bass", int'(bass_gain), -5);
    send(8'h5E, 1'b1);
    chk("R5 s2 ignored", int'(input_sel), 2);
    chk("R5 dig", int'(dig_out), 3);
    send(8'h9F, 1'b1);
    chk("R4 mute_l", int'(spk_l_mute), 1);
    chk("R8 tot_l muted", int'(tot_l), 127);
    check_all("R4 corner");

    // R10: drive the counter past its limit
    for (int i = 0; i < 220; i++) begin
      send(8'hC0 | 8'(i % 64), 1'b1);
      check_all("R10 sat");
    end
    chk("R10 final", int'(err_cnt), 255);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule